// File: doc/BRIEF.md
# Two's Complement to CSD Recoder

This block turns a signed two's-complement constant into canonical signed-digit (CSD) form. CSD is a radix-2 notation whose digits are −1, 0 or +1. The result is the unique recoding with the fewest nonzero digits. No two neighbouring digits in it are both nonzero. Coefficient-generation logic uses it to find how many shift-and-add terms a fixed multiplier needs. A multiplier that is built from the recoded constant needs one adder or subtractor fewer than the nonzero digit count reported here.

A one-cycle start strobe loads an N-bit constant. The block then produces one digit per clock, from the least significant position upward. It keeps a single carry bit and looks at a two-bit window of the sign-extended input. The output has N+1 digit positions, so that a carry out of the top input bit still has a place. When all digits are written, a done pulse marks that the digit vector and the nonzero count are valid. Both stay unchanged until the next accepted start.

Top module: `csd_recoder`

## Requirements
- R1: Digit i is held in `digits_o[2i+1:2i]` as {nonzero, sign}. 00 means 0, 10 means +1 and 11 means −1. The code 01 never appears in a result.
- R2: The sum over all positions of digit(i)·2^i equals the two's-complement value of the loaded constant, for negative and positive inputs alike.
- R3: No two adjacent positions of a result are both nonzero.
- R4: The result is the unique minimal-weight form. For example, 71 gives +1 at position 6, +1 at position 3, −1 at position 0 and 0 elsewhere.
- R5: `nz_count_o` equals the number of nonzero digits in the result. For example, 15 gives 2, so one adder is needed instead of three.
- R6: `done_o` is high for exactly one cycle. It rises N+1 clock edges after the edge that accepted the start. Digits and count then hold until the next accepted start.
- R7: A start strobe that arrives while a recoding is in progress is ignored. The running result is not disturbed and no extra done pulse follows.
- R8: While `rst_i` is high, all digits read 0, the count reads 0, done is low and the block becomes idle.
- R9: The extreme inputs −2^(N−1) and 2^(N−1)−1 are recoded correctly within the N+1 positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load strobe, accepted only when idle |
| coef_i | input | N | Two's-complement constant to recode |
| digits_o | output | 2*(N+1) | Signed-digit result, two bits per position |
| nz_count_o | output | $clog2(N+2) | Number of nonzero digits in the result |
| done_o | output | 1 | One-cycle pulse when the result is complete |

## Verification
The bench builds the recoder with N = 8 instead of the default 12. At that width all 256 input values can be swept in a few thousand cycles. The sweep therefore reaches every run-of-ones pattern, both extremes −128 and 127, and the case where a carry reaches the extra ninth position. Every result is compared against a non-adjacent-form model that works by repeated division. One run is disturbed by a second start in the middle, to show that the in-flight constant wins.

// File: rtl/csd_pkg.sv
package csd_pkg;

    // One signed digit: {nonzero, sign}
    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_POS  = 2'b10,
        DIG_NEG  = 2'b11
    } digit_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Inputs to one recoding step
    typedef struct packed {
        logic cur;    // bit at the current position
        logic nxt;    // bit one position above
        logic carry;  // carry from the step below
    } step_in_t;

    typedef struct packed {
        digit_e dig;
        logic   carry;
    } step_out_t;

    // digit = cur + carry - 2*carry_out, where carry_out is the majority of the three inputs
    function automatic step_out_t csd_step(input step_in_t s);
        step_out_t r;
        r.carry = (s.cur & s.nxt) | (s.cur & s.carry) | (s.nxt & s.carry);
        if (s.cur ^ s.carry) begin
            r.dig = s.nxt ? DIG_NEG : DIG_POS;
        end else begin
            r.dig = DIG_ZERO;
        end
        return r;
    endfunction

    function automatic logic digit_nonzero(input digit_e d);
        return d[1];
    endfunction

endpackage

// File: rtl/csd_window.sv
module csd_window #(
    parameter int N = 12,
    localparam int WW = N + 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [N-1:0] coef_i,
    output logic         cur_o,
    output logic         nxt_o
);
    logic [WW-1:0] win_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            win_q <= '0;
        end else if (load_i) begin
            // two copies of the sign bit cover the extra output position and its look-ahead
            win_q <= {{2{coef_i[N-1]}}, coef_i};
        end else if (shift_i) begin
            win_q <= {win_q[WW-1], win_q[WW-1:1]};
        end
    end

    assign cur_o = win_q[0];
    assign nxt_o = win_q[1];
endmodule

// File: rtl/csd_carry_stage.sv
module csd_carry_stage
    import csd_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   load_i,
    input  logic   step_i,
    input  logic   cur_i,
    input  logic   nxt_i,
    output digit_e dig_o
);
    logic      carry_q;
    step_in_t  sin;
    step_out_t sout;

    always_comb begin
        sin.cur   = cur_i;
        sin.nxt   = nxt_i;
        sin.carry = carry_q;
        sout      = csd_step(sin);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || load_i) begin
            carry_q <= 1'b0;
        end else if (step_i) begin
            carry_q <= sout.carry;
        end
    end

    assign dig_o = sout.dig;
endmodule

// File: rtl/csd_sequencer.sv
module csd_sequencer
    import csd_pkg::*;
#(
    parameter int N = 12,
    localparam int IW = $clog2(N + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          start_i,
    output logic          load_o,
    output logic          step_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [IW-1:0] idx_o
);
    phase_e        phase_q;
    logic [IW-1:0] idx_q;
    logic          done_q;
    logic          last;

    assign busy_o = (phase_q == PH_RUN);
    assign load_o = start_i && !busy_o;
    assign step_o = busy_o;
    assign last   = (idx_q == IW'(N));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_o) begin
                phase_q <= PH_RUN;
                idx_q   <= '0;
            end else if (step_o) begin
                if (last) begin
                    phase_q <= PH_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    idx_q <= idx_q + IW'(1);
                end
            end
        end
    end

    assign done_o = done_q;
    assign idx_o  = idx_q;
endmodule

// File: rtl/csd_digit_store.sv
module csd_digit_store
    import csd_pkg::*;
#(
    parameter int N = 12,
    localparam int P  = N + 1,
    localparam int IW = $clog2(N + 1),
    localparam int CW = $clog2(N + 2)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          clear_i,
    input  logic          wr_i,
    input  logic [IW-1:0] idx_i,
    input  digit_e        dig_i,
    output logic [2*P-1:0] digits_o,
    output logic [CW-1:0] count_o
);
    digit_e        slot_q [P];
    logic [CW-1:0] cnt_q;

    for (genvar k = 0; k < P; k++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (rst_i || clear_i) begin
                slot_q[k] <= DIG_ZERO;
            end else if (wr_i && (idx_i == IW'(k))) begin
                slot_q[k] <= dig_i;
            end
        end
        assign digits_o[2*k +: 2] = slot_q[k];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            cnt_q <= '0;
        end else if (wr_i && digit_nonzero(dig_i)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/csd_recoder.sv
module csd_recoder
    import csd_pkg::*;
#(
    parameter int N = 12,
    localparam int CW = $clog2(N + 2)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [N-1:0]     coef_i,
    output logic [2*N+1:0]   digits_o,
    output logic [CW-1:0]    nz_count_o,
    output logic             done_o
);
    localparam int IW = $clog2(N + 1);

    logic          load;
    logic          step;
    logic          run_busy;
    logic [IW-1:0] idx;
    logic          cur_bit;
    logic          nxt_bit;
    digit_e        dig;

    csd_sequencer #(.N(N)) u_seq (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .start_i(start_i),
        .load_o (load),
        .step_o (step),
        .busy_o (run_busy),
        .done_o (done_o),
        .idx_o  (idx)
    );

    csd_window #(.N(N)) u_win (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .shift_i(step),
        .coef_i (coef_i),
        .cur_o  (cur_bit),
        .nxt_o  (nxt_bit)
    );

    csd_carry_stage u_carry (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .load_i(load),
        .step_i(step),
        .cur_i (cur_bit),
        .nxt_i (nxt_bit),
        .dig_o (dig)
    );

    csd_digit_store #(.N(N)) u_store (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (load),
        .wr_i    (step),
        .idx_i   (idx),
        .dig_i   (dig),
        .digits_o(digits_o),
        .count_o (nz_count_o)
    );
endmodule

// File: rtl/csd_recoder_chk.sv
module csd_recoder_chk #(
    parameter int N = 12,
    localparam int CW = $clog2(N + 2),
    localparam int DW = 2 * (N + 1),
    localparam int SW = N + 4
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          start_i,
    input logic          busy_i,
    input logic [N-1:0]  coef_i,
    input logic [DW-1:0] digits_o,
    input logic [CW-1:0] nz_count_o,
    input logic          done_o
);
    logic signed [N-1:0] cap_q;
    int                  lat_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cap_q <= '0;
            lat_q <= 0;
        end else if (start_i && !busy_i) begin
            cap_q <= coef_i;
            lat_q <= 0;
        end else if (busy_i) begin
            lat_q <= lat_q + 1;
        end
    end

    function automatic logic signed [SW-1:0] dsum(input logic [DW-1:0] d);
        logic signed [SW-1:0] acc;
        logic signed [SW-1:0] one;
        acc = '0;
        one = 1;
        for (int i = N; i >= 0; i--) begin
            acc = acc <<< 1;
            if (d[2*i+1]) acc = d[2*i] ? acc - one : acc + one;
        end
        return acc;
    endfunction

    function automatic logic any_code01(input logic [DW-1:0] d);
        logic r;
        r = 1'b0;
        for (int i = 0; i <= N; i++) if (d[2*i+:2] == 2'b01) r = 1'b1;
        return r;
    endfunction

    function automatic logic any_adjacent(input logic [DW-1:0] d);
        logic r;
        r = 1'b0;
        for (int i = 0; i < N; i++) if (d[2*i+1] && d[2*i+3]) r = 1'b1;
        return r;
    endfunction

    function automatic int nz_of(input logic [DW-1:0] d);
        int c;
        c = 0;
        for (int i = 0; i <= N; i++) if (d[2*i+1]) c++;
        return c;
    endfunction

    p_no_code01_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !any_code01(digits_o));

    p_value_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (dsum(digits_o) == SW'(cap_q)));

    p_no_adjacent_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !any_adjacent(digits_o));

    p_count_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (int'(nz_count_o) == nz_of(digits_o)));

    p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    p_latency_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (lat_q == N + 1));

    p_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_i && !start_i) |=> ($stable(digits_o) && $stable(nz_count_o)));

    p_busy_start_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_i && start_i) |=> (busy_i || done_o));

    p_reset_r8: assert property (@(posedge clk_i)
        rst_i |=> (digits_o == '0 && nz_count_o == '0 && !done_o));
endmodule

bind csd_recoder csd_recoder_chk #(.N(N)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (start_i),
    .busy_i    (run_busy),
    .coef_i    (coef_i),
    .digits_o  (digits_o),
    .nz_count_o(nz_count_o),
    .done_o    (done_o)
);

// File: tb/sim_csd_recoder.sv
`timescale 1ns/1ps
module sim_csd_recoder;
    localparam int N  = 8;
    localparam int CW = $clog2(N + 2);
    localparam int DW = 2 * (N + 1);

    typedef struct packed {
        logic [DW-1:0] digits;
        int            count;
        int            value;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [N-1:0]  coef = '0;
    logic [DW-1:0] digits;
    logic [CW-1:0] nz_count;
    logic          done;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   n_done   = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];
    exp_t m_e;

    always #2.5 clk = ~clk;

    csd_recoder #(.N(N)) u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .start_i   (start),
        .coef_i    (coef),
        .digits_o  (digits),
        .nz_count_o(nz_count),
        .done_o    (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Non-adjacent form by repeated halving
    function automatic exp_t model(input int v);
        exp_t r;
        int   w;
        r.digits = '0;
        r.count  = 0;
        r.value  = v;
        w = v;
        for (int i = 0; i <= N; i++) begin
            if (w[0]) begin
                if ((w & 3) == 1) begin
                    r.digits[2*i +: 2] = 2'b10;
                    w = w - 1;
                end else begin
                    r.digits[2*i +: 2] = 2'b11;
                    w = w + 1;
                end
                r.count++;
            end
            w = w >>> 1;
        end
        return r;
    endfunction

    function automatic int digit_sum(input logic [DW-1:0] d);
        int s;
        s = 0;
        for (int i = 0; i <= N; i++) begin
            if (d[2*i+1]) s = d[2*i] ? s - (1 << i) : s + (1 << i);
        end
        return s;
    endfunction

    function automatic bit adjacent_nz(input logic [DW-1:0] d);
        bit r;
        r = 1'b0;
        for (int i = 0; i < N; i++) if (d[2*i+1] && d[2*i+3]) r = 1'b1;
        return r;
    endfunction

    // Monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            n_done++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected done pulse", 1, 0);
            end else begin
                m_e = exp_q.pop_front();
                check(digits == m_e.digits,
                      (m_e.value == -128 || m_e.value == 127) ? "R9" : "R4",
                      $sformatf("digits for %0d", m_e.value),
                      longint'(digits), longint'(m_e.digits));
                check(int'(nz_count) == m_e.count, "R5",
                      $sformatf("count for %0d", m_e.value),
                      longint'(nz_count), longint'(m_e.count));
                check(digit_sum(digits) == m_e.value, "R2",
                      $sformatf("weighted sum for %0d", m_e.value),
                      longint'(digit_sum(digits)), longint'(m_e.value));
                check(!adjacent_nz(digits), "R3",
                      $sformatf("adjacent nonzero for %0d", m_e.value),
                      longint'(adjacent_nz(digits)), 0);
            end
        end
    end

    // Driver: one recoding, optionally disturbed by a second start
    task automatic run_one(input int v, input bit poke, input bit check_timing);
        int            cyc;
        logic [DW-1:0] held;
        @(negedge clk);
        coef  = N'(v);
        start = 1'b1;
        exp_q.push_back(model(v));
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        if (poke) begin
            repeat (2) @(negedge clk);
            cyc += 2;
            coef  = ~N'(v);
            start = 1'b1;        // R7: must be ignored while busy
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        if (check_timing) begin
            // accepted at edge 1, done visible after edge N+2: N+1 edges later
            check(cyc == N + 2, "R6", "start-to-done latency (negedges)", cyc, N + 2);
            held = digits;
            repeat (3) begin
                @(negedge clk);
                check(!done, "R6", "done longer than one cycle", longint'(done), 0);
                check(digits == held, "R6", "digits held after done",
                      longint'(digits), longint'(held));
            end
        end
    endtask

    initial begin
        int done_before;
        repeat (3) @(negedge clk);
        check(digits == '0, "R8", "digits in reset", longint'(digits), 0);
        check(nz_count == '0, "R8", "count in reset", longint'(nz_count), 0);
        check(!done, "R8", "done in reset", longint'(done), 0);
        rst = 1'b0;

        // R4: 71 -> +1 @6, +1 @3, -1 @0 (code 10/10/11)
        run_one(71, 1'b0, 1'b1);
        check(digits == 18'b00_10_00_00_10_00_00_11 && int'(nz_count) == 3, "R4",
              "71 pattern", longint'(digits), 18'b00_10_00_00_10_00_00_11);
        // R5: 15 -> +1 @4, -1 @0: two digits, one adder
        run_one(15, 1'b0, 1'b1);
        check(int'(nz_count) == 2, "R5", "15 nonzero count", longint'(nz_count), 2);
        // R1: -1 -> single -1 digit, code 11 at position 0
        run_one(-1, 1'b0, 1'b1);
        check(digits[1:0] == 2'b11 && digits[DW-1:2] == '0, "R1", "-1 encoding",
              longint'(digits), 3);

        // R7: second start during a run
        done_before = n_done;
        run_one(85, 1'b1, 1'b1);
        check(n_done - done_before == 1, "R7", "done pulses for disturbed run",
              n_done - done_before, 1);

        // R9 and sweep of all inputs
        run_one(-128, 1'b0, 1'b1);
        run_one(127, 1'b0, 1'b1);
        for (int v = -128; v < 128; v++) run_one(v, 1'b0, v[3:0] == 4'd5);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6", "results still pending", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(100000 * 5);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "R6", "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule